// File: doc/BRIEF.md
# Configurable Modulo Step Counter

A synchronous binary counter whose step size, direction mode and wrap behaviour are fixed by parameters. The count moves by a constant step on every enabled clock edge. Depending on configuration it counts only up, only down, or in a direction chosen per cycle by an input pin. An optional restricted mode returns the count to zero one edge after it lands exactly on a programmed final value. Without that mode the count wraps modulo 2^WIDTH.

Beside counting, the block accepts a parallel load, a synchronous clear to zero, a synchronous set to all ones, and a synchronous initialise to a parameter value. Parameters fix the priority between clear and set, and whether the three synchronous controls need the clock enable. Parameters also fix the active level of the load strobe and the value taken at reset. A flag output rises combinationally while the count equals a parameter threshold. Controls that are configured away are treated as inactive. Illegal parameter sets stop elaboration.

Top module: `step_counter`

## Requirements
- R1: While rst_ni is low, and after it rises until the first effective edge, q_o equals POR_VAL.
- R2: On an enabled edge with no control active, q_o changes by STEP. In MODE CNT_UPDOWN it counts up when up_i is 1 and down when it is 0. In CNT_UP and CNT_DOWN, up_i has no effect.
- R3: With ce_i low and no synchronous control acting, q_o holds its value.
- R4: Without restricted mode, counting wraps modulo 2^WIDTH in both directions. For example, 254+3 gives 1 and 1-3 gives 254 at WIDTH 8.
- R5: Restricted up mode: on the edge after q_o equals FINAL_VAL, q_o becomes 0.
- R6: Restricted down mode: on the edge after q_o equals FINAL_VAL, q_o becomes 0. The next enabled edge gives 0-STEP modulo 2^WIDTH.
- R7: Restricted detection is equality only. A count that is above FINAL_VAL in up mode keeps stepping and wraps at the full width.
- R8: sclr_i gives 0 and sset_i gives all ones. When both are active, clear wins when SET_WINS is 0 and set wins when SET_WINS is 1.
- R9: sinit_i loads INIT_VAL into q_o.
- R10: Clear, set and init take precedence over load, and load takes precedence over counting. A load needs ce_i high. The strobe is active high when LOAD_HIGH is 1 and active low when it is 0.
- R11: When SYNC_OVER_CE is 1, clear, set and init act even with ce_i low. When it is 0, they are ignored while ce_i is low.
- R12: thresh_o is 1 exactly while q_o equals THRESH_VAL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset to POR_VAL |
| ce_i | input | 1 | Clock enable, active high |
| up_i | input | 1 | Direction in up/down mode: 1 up, 0 down |
| sclr_i | input | 1 | Synchronous clear to zero |
| sset_i | input | 1 | Synchronous set to all ones |
| sinit_i | input | 1 | Synchronous load of INIT_VAL |
| load_i | input | 1 | Parallel load strobe, polarity by LOAD_HIGH |
| ld_val_i | input | WIDTH | Parallel load value |
| q_o | output | WIDTH | Count value |
| thresh_o | output | 1 | High while count equals THRESH_VAL |

## Verification
The up/down counter is driven up and then down with step 3, which separates the direction decode from the step size. Loads just below the top of the range and steps across it in each direction show that the count wraps at the full width. A restricted up counter with step 4 is run onto its final value, and is then loaded with values off the step grid and above the final value. This separates an equality test from a greater-or-equal test. Pairs of simultaneous controls, each applied with the enable high and with it low, tell apart every priority ordering and both enable-gating options.

// File: rtl/msc_pkg.sv
package msc_pkg;
  typedef enum logic [1:0] {CNT_UP, CNT_DOWN, CNT_UPDOWN} cnt_mode_e;
  typedef enum logic [2:0] {OP_HOLD, OP_CLR, OP_SET, OP_INIT, OP_LOAD, OP_STEP} cnt_op_e;
endpackage

// File: rtl/msc_ctrl.sv
module msc_ctrl #(
  parameter bit HAS_CE       = 1,
  parameter bit HAS_SCLR     = 1,
  parameter bit HAS_SSET     = 1,
  parameter bit HAS_SINIT    = 0,
  parameter bit HAS_LOAD     = 1,
  parameter bit LOAD_HIGH    = 1,
  parameter bit SYNC_OVER_CE = 1,
  parameter bit SET_WINS     = 0
) (
  input  logic             ce_i,
  input  logic             sclr_i,
  input  logic             sset_i,
  input  logic             sinit_i,
  input  logic             load_i,
  output msc_pkg::cnt_op_e op_o
);
  import msc_pkg::*;

  logic ce_e, gate, clr_a, set_a, ini_a, ld_a;

  always_comb begin
    ce_e  = HAS_CE ? ce_i : 1'b1;
    gate  = SYNC_OVER_CE ? 1'b1 : ce_e;
    clr_a = HAS_SCLR  & sclr_i  & gate;
    set_a = HAS_SSET  & sset_i  & gate;
    ini_a = HAS_SINIT & sinit_i & gate;
    ld_a  = HAS_LOAD  & (load_i == LOAD_HIGH) & ce_e;
  end

  // priority: clear/set (ordered by SET_WINS) > init > load > step
  always_comb begin
    op_o = OP_HOLD;
    if (clr_a && !(SET_WINS && set_a)) op_o = OP_CLR;
    else if (set_a)                    op_o = OP_SET;
    else if (ini_a)                    op_o = OP_INIT;
    else if (ce_e && ld_a)             op_o = OP_LOAD;
    else if (ce_e)                     op_o = OP_STEP;
  end
endmodule

// File: rtl/msc_step.sv
module msc_step #(
  parameter int                  WIDTH     = 8,
  parameter msc_pkg::cnt_mode_e  MODE      = msc_pkg::CNT_UPDOWN,
  parameter logic [WIDTH-1:0]    STEP      = 1,
  parameter bit                  RESTRICT  = 0,
  parameter logic [WIDTH-1:0]    FINAL_VAL = 1
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] nxt_o
);
  import msc_pkg::*;

  logic go_up;
  logic hit;

  generate
    if (MODE == CNT_UP) begin : g_up
      assign go_up = 1'b1;
    end else if (MODE == CNT_DOWN) begin : g_dn
      assign go_up = 1'b0;
    end else begin : g_ud
      assign go_up = up_i;
    end
    if (RESTRICT) begin : g_rst
      assign hit = (q_i == FINAL_VAL);
    end else begin : g_free
      assign hit = 1'b0;
    end
  endgenerate

  always_comb begin
    if (hit)        nxt_o = '0;
    else if (go_up) nxt_o = q_i + STEP;
    else            nxt_o = q_i - STEP;
  end
endmodule

// File: rtl/msc_thresh.sv
module msc_thresh #(
  parameter int               WIDTH      = 8,
  parameter bit               HAS_THRESH = 1,
  parameter logic [WIDTH-1:0] THRESH_VAL = 1
) (
  input  logic [WIDTH-1:0] q_i,
  output logic             hit_o
);
  generate
    if (HAS_THRESH) begin : g_on
      assign hit_o = (q_i == THRESH_VAL);
    end else begin : g_off
      assign hit_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/step_counter.sv
module step_counter #(
  parameter int                  WIDTH        = 8,
  parameter msc_pkg::cnt_mode_e  MODE         = msc_pkg::CNT_UPDOWN,
  parameter logic [WIDTH-1:0]    STEP         = 3,
  parameter bit                  RESTRICT     = 0,
  parameter logic [WIDTH-1:0]    FINAL_VAL    = 1,
  parameter bit                  HAS_CE       = 1,
  parameter bit                  HAS_SCLR     = 1,
  parameter bit                  HAS_SSET     = 1,
  parameter bit                  HAS_SINIT    = 0,
  parameter bit                  HAS_LOAD     = 1,
  parameter bit                  LOAD_HIGH    = 1,
  parameter bit                  SYNC_OVER_CE = 1,
  parameter bit                  SET_WINS     = 0,
  parameter logic [WIDTH-1:0]    INIT_VAL     = 0,
  parameter logic [WIDTH-1:0]    POR_VAL      = 5,
  parameter bit                  HAS_THRESH   = 1,
  parameter logic [WIDTH-1:0]    THRESH_VAL   = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             up_i,
  input  logic             sclr_i,
  input  logic             sset_i,
  input  logic             sinit_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] ld_val_i,
  output logic [WIDTH-1:0] q_o,
  output logic             thresh_o
);
  import msc_pkg::*;

  localparam logic [WIDTH-1:0] DN_SPAN = '0 - FINAL_VAL;

  generate
    if (STEP == '0) begin : g_bad_step
      $error("step_counter: STEP must be nonzero");
    end
    if (RESTRICT && MODE == CNT_UPDOWN) begin : g_bad_ud
      $error("step_counter: restricted mode needs a fixed direction");
    end
    if (RESTRICT && HAS_SSET) begin : g_bad_set
      $error("step_counter: restricted mode excludes set");
    end
    if (HAS_SINIT && (HAS_SCLR || HAS_SSET)) begin : g_bad_init
      $error("step_counter: init excludes clear and set");
    end
    if (RESTRICT && MODE == CNT_UP && STEP != '0 &&
        ((FINAL_VAL % STEP) != '0 || STEP > FINAL_VAL)) begin : g_bad_fup
      $error("step_counter: final value off the up step grid");
    end
    if (RESTRICT && MODE == CNT_DOWN && STEP != '0 &&
        ((DN_SPAN % STEP) != '0 || STEP > DN_SPAN)) begin : g_bad_fdn
      $error("step_counter: final value off the down step grid");
    end
  endgenerate

  cnt_op_e          op;
  logic [WIDTH-1:0] step_nxt;
  logic [WIDTH-1:0] q_q;
  logic             unused_ins;

  // inputs removed by configuration still reach this sink
  assign unused_ins = ^{up_i, sclr_i, sset_i, sinit_i, load_i, ce_i, ld_val_i};

  msc_ctrl #(
    .HAS_CE(HAS_CE), .HAS_SCLR(HAS_SCLR), .HAS_SSET(HAS_SSET),
    .HAS_SINIT(HAS_SINIT), .HAS_LOAD(HAS_LOAD), .LOAD_HIGH(LOAD_HIGH),
    .SYNC_OVER_CE(SYNC_OVER_CE), .SET_WINS(SET_WINS)
  ) u_ctrl (
    .ce_i(ce_i), .sclr_i(sclr_i), .sset_i(sset_i), .sinit_i(sinit_i),
    .load_i(load_i), .op_o(op)
  );

  msc_step #(
    .WIDTH(WIDTH), .MODE(MODE), .STEP(STEP), .RESTRICT(RESTRICT),
    .FINAL_VAL(FINAL_VAL)
  ) u_step (
    .q_i(q_q), .up_i(up_i), .nxt_o(step_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= POR_VAL;
    end else begin
      unique case (op)
        OP_CLR:  q_q <= '0;
        OP_SET:  q_q <= '1;
        OP_INIT: q_q <= INIT_VAL;
        OP_LOAD: q_q <= ld_val_i;
        OP_STEP: q_q <= step_nxt;
        default: q_q <= q_q;
      endcase
    end
  end

  assign q_o = q_q;

  msc_thresh #(
    .WIDTH(WIDTH), .HAS_THRESH(HAS_THRESH), .THRESH_VAL(THRESH_VAL)
  ) u_thr (
    .q_i(q_q), .hit_o(thresh_o)
  );
endmodule

// File: rtl/step_counter_chk.sv
module step_counter_chk #(
  parameter int                  WIDTH        = 8,
  parameter msc_pkg::cnt_mode_e  MODE         = msc_pkg::CNT_UPDOWN,
  parameter logic [WIDTH-1:0]    STEP         = 3,
  parameter bit                  RESTRICT     = 0,
  parameter logic [WIDTH-1:0]    FINAL_VAL    = 1,
  parameter bit                  HAS_CE       = 1,
  parameter bit                  HAS_SCLR     = 1,
  parameter bit                  HAS_SSET     = 1,
  parameter bit                  HAS_SINIT    = 0,
  parameter bit                  HAS_LOAD     = 1,
  parameter bit                  LOAD_HIGH    = 1,
  parameter bit                  SYNC_OVER_CE = 1,
  parameter bit                  SET_WINS     = 0,
  parameter logic [WIDTH-1:0]    INIT_VAL     = 0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_i,
  input logic             up_i,
  input logic             sclr_i,
  input logic             sset_i,
  input logic             sinit_i,
  input logic             load_i,
  input logic [WIDTH-1:0] ld_val_i,
  input logic [WIDTH-1:0] q_o
);
  import msc_pkg::*;

  logic ce_e, gate, clr, set, ini, ld, quiet, dir_up, at_final;

  always_comb begin
    ce_e     = HAS_CE ? ce_i : 1'b1;
    gate     = SYNC_OVER_CE ? 1'b1 : ce_e;
    clr      = HAS_SCLR  & sclr_i  & gate;
    set      = HAS_SSET  & sset_i  & gate;
    ini      = HAS_SINIT & sinit_i & gate;
    ld       = HAS_LOAD  & (load_i == LOAD_HIGH) & ce_e;
    quiet    = !clr && !set && !ini;
    dir_up   = (MODE == CNT_UP) || (MODE == CNT_UPDOWN && up_i);
    at_final = RESTRICT && (q_o == FINAL_VAL);
  end

  assert_clear_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !(SET_WINS && set)) |=> (q_o == '0));

  assert_set_ones_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set && !(clr && !SET_WINS)) |=> (q_o == '1));

  assert_init_value_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ini && !clr && !set) |=> (q_o == INIT_VAL));

  assert_load_taken_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && ld) |=> (q_o == $past(ld_val_i)));

  assert_hold_no_ce_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && !ce_e) |=> $stable(q_o));

  assert_step_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && ce_e && !ld && dir_up && !at_final) |=> (q_o == $past(q_o) + STEP));

  assert_step_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && ce_e && !ld && !dir_up && !at_final) |=> (q_o == $past(q_o) - STEP));

  assert_final_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && ce_e && !ld && at_final) |=> (q_o == '0));
endmodule

bind step_counter step_counter_chk #(
  .WIDTH(WIDTH), .MODE(MODE), .STEP(STEP), .RESTRICT(RESTRICT),
  .FINAL_VAL(FINAL_VAL), .HAS_CE(HAS_CE), .HAS_SCLR(HAS_SCLR),
  .HAS_SSET(HAS_SSET), .HAS_SINIT(HAS_SINIT), .HAS_LOAD(HAS_LOAD),
  .LOAD_HIGH(LOAD_HIGH), .SYNC_OVER_CE(SYNC_OVER_CE), .SET_WINS(SET_WINS),
  .INIT_VAL(INIT_VAL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .up_i(up_i), .sclr_i(sclr_i),
  .sset_i(sset_i), .sinit_i(sinit_i), .load_i(load_i), .ld_val_i(ld_val_i),
  .q_o(q_o)
);

// File: tb/step_counter_test.sv
module step_counter_test;
  import msc_pkg::*;

  localparam int CLK_P = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_i = 1'b0, up_i = 1'b0, sclr_i = 1'b0, sset_i = 1'b0;
  logic sinit_i = 1'b0, load_i = 1'b0;
  logic [7:0] ld_val_i = '0;
  logic [7:0] q_a, q_b, q_c;
  logic [3:0] q_d;
  logic thr_a, thr_b, thr_c, thr_d;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  // up/down, step 3, clear/set/load, controls override enable
  step_counter uut (
    .clk_i, .rst_ni, .ce_i, .up_i, .sclr_i, .sset_i, .sinit_i, .load_i,
    .ld_val_i, .q_o(q_a), .thresh_o(thr_a));

  // restricted up, step 4, final 20, init 8, active-low load, enable gates controls
  step_counter #(
    .WIDTH(8), .MODE(CNT_UP), .STEP(4), .RESTRICT(1), .FINAL_VAL(20),
    .HAS_SCLR(0), .HAS_SSET(0), .HAS_SINIT(1), .HAS_LOAD(1), .LOAD_HIGH(0),
    .SYNC_OVER_CE(0), .INIT_VAL(8), .POR_VAL(0), .THRESH_VAL(20)
  ) u_rup (
    .clk_i, .rst_ni, .ce_i, .up_i, .sclr_i, .sset_i, .sinit_i, .load_i,
    .ld_val_i, .q_o(q_b), .thresh_o(thr_b));

  // restricted down, step 4, final 240
  step_counter #(
    .WIDTH(8), .MODE(CNT_DOWN), .STEP(4), .RESTRICT(1), .FINAL_VAL(240),
    .HAS_SCLR(0), .HAS_SSET(0), .HAS_LOAD(0), .POR_VAL(252), .THRESH_VAL(240)
  ) u_rdn (
    .clk_i, .rst_ni, .ce_i, .up_i, .sclr_i, .sset_i, .sinit_i, .load_i,
    .ld_val_i, .q_o(q_c), .thresh_o(thr_c));

  // 4-bit up, set wins, enable gates controls
  step_counter #(
    .WIDTH(4), .MODE(CNT_UP), .STEP(1), .HAS_LOAD(0), .SET_WINS(1),
    .SYNC_OVER_CE(0), .POR_VAL(0), .HAS_THRESH(0)
  ) u_set (
    .clk_i, .rst_ni, .ce_i, .up_i, .sclr_i, .sset_i, .sinit_i, .load_i,
    .ld_val_i(ld_val_i[3:0]), .q_o(q_d), .thresh_o(thr_d));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic idle();
    ce_i = 0; up_i = 0; sclr_i = 0; sset_i = 0; sinit_i = 0; load_i = 0;
    ld_val_i = '0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    idle();
    rst_ni = 0;
    tick(2);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic t_updown();
    do_reset();
    check("R1 por value", q_a, 5);
    check("R12 thresh low", thr_a, 0);
    ce_i = 1; up_i = 1; tick(2);
    check("R2 up by 3", q_a, 11);
    check("R12 thresh high", thr_a, 1);
    up_i = 0; tick();
    check("R2 down by 3", q_a, 8);
    check("R12 thresh drops", thr_a, 0);
    ce_i = 0; up_i = 1; tick(2);
    check("R3 hold ce low", q_a, 8);
  endtask

  task automatic t_wrap();
    do_reset();
    ce_i = 1; load_i = 1; ld_val_i = 254; tick();
    check("R10 load value", q_a, 254);
    load_i = 0; up_i = 1; tick();
    check("R4 wrap up", q_a, 1);
    up_i = 0; tick();
    check("R4 wrap down", q_a, 254);
  endtask

  task automatic t_ctrl();
    do_reset();
    ce_i = 0; sclr_i = 1; tick();
    check("R11 clear with ce low", q_a, 0);
    sclr_i = 0; sset_i = 1; tick();
    check("R8 set ones", q_a, 255);
    sclr_i = 1; sset_i = 1; tick();
    check("R8 clear wins", q_a, 0);
    sset_i = 0; sclr_i = 0; ce_i = 1; up_i = 1; tick();
    check("R2 step after clear", q_a, 3);
    sclr_i = 1; load_i = 1; ld_val_i = 77; tick();
    check("R10 clear over load", q_a, 0);
    sclr_i = 0; ce_i = 0; tick();
    check("R10 load needs ce", q_a, 0);
    ce_i = 1; tick();
    check("R10 load taken", q_a, 77);
  endtask

  task automatic t_rup();
    do_reset();
    load_i = 1;
    check("R1 por zero", q_b, 0);
    ce_i = 1; tick(5);
    check("R5 reach final", q_b, 20);
    check("R12 thresh at final", thr_b, 1);
    tick();
    check("R5 final to zero", q_b, 0);
    tick();
    check("R5 restart", q_b, 4);
    ce_i = 0; sinit_i = 1; tick();
    check("R11 init gated by ce", q_b, 4);
    ce_i = 1; tick();
    check("R9 init value", q_b, 8);
    sinit_i = 0; tick();
    check("R2 step 4", q_b, 12);
    sinit_i = 1; load_i = 0; ld_val_i = 40; tick();
    check("R10 init over load", q_b, 8);
    sinit_i = 0; ld_val_i = 22; tick();
    check("R10 active-low load", q_b, 22);
    load_i = 1; tick();
    check("R7 past final continues", q_b, 26);
    load_i = 0; ld_val_i = 254; tick();
    load_i = 1; tick();
    check("R7 full width wrap", q_b, 2);
  endtask

  task automatic t_rdn();
    do_reset();
    check("R1 por 252", q_c, 252);
    ce_i = 1; up_i = 1; tick();
    check("R2 up_i ignored", q_c, 248);
    tick(2);
    check("R6 reach final", q_c, 240);
    tick();
    check("R6 final to zero", q_c, 0);
    tick();
    check("R6 continues down", q_c, 252);
  endtask

  task automatic t_setwin();
    do_reset();
    ce_i = 1; tick();
    check("R2 4-bit step", q_d, 1);
    sclr_i = 1; sset_i = 1; tick();
    check("R8 set wins", q_d, 15);
    sset_i = 0; ce_i = 0; tick();
    check("R11 clear gated by ce", q_d, 15);
    ce_i = 1; tick();
    check("R8 clear alone", q_d, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_updown();
    t_wrap();
    t_ctrl();
    t_rup();
    t_rdn();
    t_setwin();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule